// File: doc/BRIEF.md
# Two-Level Interrupt Mask and Router

This block sits between a set of level-sensitive device interrupt lines and the cores of a small multi-core cluster. For every core it produces a vector showing which sources that core should see. A source reaches a core only when two gates are open. The first is a global enable that the whole cluster shares. The second is a mask bit held separately for each core. Sources at or above a fixed boundary index are shared between cores. Each of these also carries a small routing mask that selects the cores allowed to receive it.

Software controls the block over a simple 32-bit register bus. Enable and mask bits are never written as bitmaps. Instead, software writes a source number to a "set" address or to a "clear" address, so two cores cannot corrupt each other's updates. Address bit 11 selects the per-core banked window. Inside that window, the core-id input that comes with the access picks which core's mask bank is changed. The pending vectors are combinational from the device lines and the stored state, so a line change appears in the same cycle.

Top module: `irq_mask_router`

## Requirements
- R1: A read of shared address 0x000 returns the number of sources in bits 12:2, with every other bit zero. All read data is registered: it appears in the cycle after the read request and holds until the next read.
- R2: Writing a source number N (N < NUM_SRC) to shared address 0x030 sets the global enable of source N and leaves every other enable unchanged.
- R3: Writing a source number N (N < NUM_SRC) to shared address 0x034 clears the global enable of source N and leaves every other enable unchanged.
- R4: Writing a source number N to banked address 0x848 sets the mask of source N for the core given on `bus_core`. Writing N to 0x84C clears that mask. The masks of all other cores stay unchanged.
- R5: Writing to shared address 0x100+4·N stores data bits NUM_CORES-1:0 as the routing mask of source N. A read of that address returns the routing mask in bits NUM_CORES-1:0 and again at bit 8 upward, with all other bits zero.
- R6: For a source s below PERCORE_SRCS, pending bit c·NUM_SRC+s is high exactly when the line is high, the global enable is set and core c's mask is clear. The routing mask has no effect on these sources.
- R7: For a source s at or above PERCORE_SRCS, the pending bit additionally needs routing bit c of source s to be set.
- R8: After reset every global enable is clear, every mask is set and every routing mask is zero. As a result, no pending bit is high even with all lines high.
- R9: Writes whose source number is NUM_SRC or more, and writes to unmapped addresses, change no state. Reads of unmapped addresses return zero.
- R10: A change on `irq_line` shows on `irq_pend` in the same cycle. A register write takes effect on `irq_pend` from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_line | input | NUM_SRC | Level-sensitive device interrupt lines |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bit 11 selects the per-core window |
| bus_wdata | input | 32 | Write data (source number or routing mask) |
| bus_core | input | CORE_W | Id of the core making the access |
| bus_rdata | output | 32 | Registered read data |
| irq_pend | output | NUM_CORES·NUM_SRC | Pending vector; bit c·NUM_SRC+s is source s for core c |

## Verification
Two things can land on the same clock edge: a device line changing level, and a mask or enable write aimed at that same source. The bench provokes this by moving `irq_line` between the write's set-up and the accepting edge. It judges the result after the edge against a model that applies the new state to the new line levels. A mask write from one core, made while another core has the same source pending, is also checked: the other core's pending bit must stay high.

// File: rtl/irq_mr_pkg.sv
package irq_mr_pkg;
  localparam int unsigned BANK_BIT = 11;

  localparam logic [11:0] OFS_CTRL    = 12'h000;
  localparam logic [11:0] OFS_EN_SET  = 12'h030;
  localparam logic [11:0] OFS_EN_CLR  = 12'h034;
  localparam logic [11:0] OFS_MSK_SET = 12'h048;
  localparam logic [11:0] OFS_MSK_CLR = 12'h04C;
  localparam logic [11:0] OFS_RT_BASE = 12'h100;

  typedef enum logic [2:0] {
    OP_NONE, OP_EN_SET, OP_EN_CLR, OP_MSK_SET, OP_MSK_CLR, OP_RT_WR
  } wr_op_e;

  typedef enum logic [1:0] {
    RD_ZERO, RD_CTRL, RD_ROUTE
  } rd_sel_e;
endpackage

// File: rtl/irq_mr_decode.sv
module irq_mr_decode
  import irq_mr_pkg::*;
#(
  parameter int NUM_SRC   = 36,
  parameter int NUM_CORES = 2,
  parameter int IDX_W     = 6,
  parameter int CORE_W    = 1
) (
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [CORE_W-1:0]    bus_core,
  output wr_op_e               op,
  output logic [IDX_W-1:0]     idx,
  output logic [IDX_W-1:0]     rt_idx,
  output logic [NUM_CORES-1:0] rt_val,
  output logic                 rd_en,
  output rd_sel_e              rd_sel
);
  logic        bank;
  logic [11:0] off;
  logic [11:0] rt_off;
  logic        rt_hit;
  logic        idx_ok;
  logic        core_ok;

  always_comb begin
    bank    = bus_addr[BANK_BIT];
    off     = bus_addr & 12'h7FF;
    rt_off  = bus_addr - OFS_RT_BASE;
    rt_hit  = !bank && (bus_addr >= OFS_RT_BASE) && (rt_off[1:0] == 2'b00)
              && ({22'b0, rt_off[11:2]} < 32'(NUM_SRC));
    idx_ok  = bus_wdata < 32'(NUM_SRC);
    core_ok = 32'(bus_core) < 32'(NUM_CORES);
    idx     = bus_wdata[IDX_W-1:0];
    rt_idx  = rt_off[IDX_W+1:2];
    rt_val  = bus_wdata[NUM_CORES-1:0];

    op = OP_NONE;
    if (bus_valid && bus_write) begin
      if (!bank) begin
        if (bus_addr == OFS_EN_SET && idx_ok)      op = OP_EN_SET;
        else if (bus_addr == OFS_EN_CLR && idx_ok) op = OP_EN_CLR;
        else if (rt_hit)                           op = OP_RT_WR;
      end else if (idx_ok && core_ok) begin
        if (off == OFS_MSK_SET)      op = OP_MSK_SET;
        else if (off == OFS_MSK_CLR) op = OP_MSK_CLR;
      end
    end

    rd_en = bus_valid && !bus_write;
    if (!bank && bus_addr == OFS_CTRL) rd_sel = RD_CTRL;
    else if (rt_hit)                   rd_sel = RD_ROUTE;
    else                               rd_sel = RD_ZERO;
  end
endmodule

// File: rtl/irq_mr_state.sv
module irq_mr_state
  import irq_mr_pkg::*;
#(
  parameter int NUM_SRC   = 36,
  parameter int NUM_CORES = 2,
  parameter int IDX_W     = 6,
  parameter int CORE_W    = 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  wr_op_e                              op,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [CORE_W-1:0]                   core,
  input  logic [IDX_W-1:0]                    rt_idx,
  input  logic [NUM_CORES-1:0]                rt_val,
  output logic [NUM_SRC-1:0]                  en_q,
  output logic [NUM_CORES-1:0][NUM_SRC-1:0]   msk_q,
  output logic [NUM_SRC-1:0][NUM_CORES-1:0]   rt_q
);
  logic [NUM_SRC-1:0]                en_d;
  logic [NUM_CORES-1:0][NUM_SRC-1:0] msk_d;
  logic [NUM_SRC-1:0][NUM_CORES-1:0] rt_d;
  logic en_ce, msk_ce, rt_ce;

  always_comb begin
    en_ce  = (op == OP_EN_SET) || (op == OP_EN_CLR);
    msk_ce = (op == OP_MSK_SET) || (op == OP_MSK_CLR);
    rt_ce  = (op == OP_RT_WR);
    en_d   = en_q;
    msk_d  = msk_q;
    rt_d   = rt_q;
    en_d[idx]        = (op == OP_EN_SET);
    msk_d[core][idx] = (op == OP_MSK_SET);
    rt_d[rt_idx]     = rt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msk_q <= '1;
    else if (msk_ce) msk_q <= msk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rt_q <= '0;
    else if (rt_ce) rt_q <= rt_d;
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EN_SET) |=> en_q[$past(idx)]);
  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EN_CLR) |=> !en_q[$past(idx)]);
  assert_msk_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MSK_SET) |=> msk_q[$past(core)][$past(idx)]);
  assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> ($stable(en_q) && $stable(msk_q) && $stable(rt_q)));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank_chk
    assert_bank_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_MSK_SET || op == OP_MSK_CLR) && 32'(core) != c)
        |=> $stable(msk_q[c]));
  end
endmodule

// File: rtl/irq_mr_route.sv
module irq_mr_route #(
  parameter int NUM_SRC      = 36,
  parameter int NUM_CORES    = 2,
  parameter int PERCORE_SRCS = 29
) (
  input  logic [NUM_SRC-1:0]                irq_line,
  input  logic [NUM_SRC-1:0]                en_q,
  input  logic [NUM_CORES-1:0][NUM_SRC-1:0] msk_q,
  input  logic [NUM_SRC-1:0][NUM_CORES-1:0] rt_q,
  output logic [NUM_CORES*NUM_SRC-1:0]      irq_pend
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s < PERCORE_SRCS) begin : g_local
        assign irq_pend[c*NUM_SRC+s] = irq_line[s] & en_q[s] & ~msk_q[c][s];
      end else begin : g_shared
        assign irq_pend[c*NUM_SRC+s] = irq_line[s] & en_q[s] & ~msk_q[c][s]
                                       & rt_q[s][c];
      end
    end
  end
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_mr_pkg::*;
#(
  parameter int NUM_SRC      = 36,
  parameter int NUM_CORES    = 2,
  parameter int PERCORE_SRCS = 29,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            irq_line,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [11:0]                   bus_addr,
  input  logic [31:0]                   bus_wdata,
  input  logic [CORE_W-1:0]             bus_core,
  output logic [31:0]                   bus_rdata,
  output logic [NUM_CORES*NUM_SRC-1:0]  irq_pend
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  wr_op_e                            op;
  rd_sel_e                           rd_sel;
  logic                              rd_en;
  logic [IDX_W-1:0]                  idx, rt_idx;
  logic [NUM_CORES-1:0]              rt_val;
  logic [NUM_SRC-1:0]                en_q;
  logic [NUM_CORES-1:0][NUM_SRC-1:0] msk_q;
  logic [NUM_SRC-1:0][NUM_CORES-1:0] rt_q;

  irq_mr_decode #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W),
                  .CORE_W(CORE_W)) u_decode (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_core(bus_core), .op(op), .idx(idx),
    .rt_idx(rt_idx), .rt_val(rt_val), .rd_en(rd_en), .rd_sel(rd_sel));

  irq_mr_state #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W),
                 .CORE_W(CORE_W)) u_state (
    .clk(clk), .rst_n(rst_int_n), .op(op), .idx(idx), .core(bus_core),
    .rt_idx(rt_idx), .rt_val(rt_val), .en_q(en_q), .msk_q(msk_q), .rt_q(rt_q));

  irq_mr_route #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES),
                 .PERCORE_SRCS(PERCORE_SRCS)) u_route (
    .irq_line(irq_line), .en_q(en_q), .msk_q(msk_q), .rt_q(rt_q),
    .irq_pend(irq_pend));

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    case (rd_sel)
      RD_CTRL:  rd_d[12:2] = 11'(NUM_SRC);
      RD_ROUTE: begin
        rd_d[NUM_CORES-1:0]  = rt_q[rt_idx];
        rd_d[8 +: NUM_CORES] = rt_q[rt_idx];
      end
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_d;
  end

  assert_ctrl_read_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_valid && !bus_write && bus_addr == OFS_CTRL)
      |=> (bus_rdata == {19'b0, 11'(NUM_SRC), 2'b00}));
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_pend_chk
    assert_pend_gated_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
      ((irq_pend[c*NUM_SRC +: NUM_SRC] & ~(irq_line & en_q & ~msk_q[c])) == '0));
  end
endmodule

// File: tb/irq_mask_router_test.sv
module irq_mask_router_test;
  localparam int NS = 36;
  localparam int NC = 2;
  localparam int PC = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_line = '0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [0:0]    bus_core = '0;
  logic [31:0]   bus_rdata;
  logic [NC*NS-1:0] irq_pend;

  irq_mask_router #(.NUM_SRC(NS), .NUM_CORES(NC), .PERCORE_SRCS(PC)) uut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_core(bus_core), .bus_rdata(bus_rdata), .irq_pend(irq_pend));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [NS-1:0] m_en;
  logic [NS-1:0] m_msk [NC];
  logic [NC-1:0] m_rt [NS];

  function automatic logic [NC*NS-1:0] exp_pend();
    logic [NC*NS-1:0] e = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        e[c*NS+s] = irq_line[s] & m_en[s] & ~m_msk[c][s] & ((s < PC) ? 1'b1 : m_rt[s][c]);
    return e;
  endfunction

  task automatic chk_pend(string req);
    logic [NC*NS-1:0] e = exp_pend();
    n_chk++;
    if (irq_pend !== e) begin
      n_fail++;
      $display("FAIL %s pend actual=%h expected=%h", req, irq_pend, e);
    end
  endtask

  task automatic chk_val(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, int core);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_core = 1'(core);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    if (d < NS) begin
      if (a == 12'h030) m_en[d] = 1'b1;
      if (a == 12'h034) m_en[d] = 1'b0;
      if (a == 12'h848) m_msk[core][d] = 1'b1;
      if (a == 12'h84C) m_msk[core][d] = 1'b0;
    end
    if (a >= 12'h100 && a < 12'h100 + 4*NS && a[1:0] == 2'b00)
      m_rt[(a - 12'h100) >> 2] = d[NC-1:0];
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    v = bus_rdata;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    m_en = '0;
    for (int c = 0; c < NC; c++) m_msk[c] = '1;
    for (int s = 0; s < NS; s++) m_rt[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8: reset state, all lines high, nothing pending
    irq_line = '1;
    #1 chk_pend("R8");
    chk_val("R8 no pend", 32'(irq_pend != '0), 32'd0);
    rd(12'h000, v); chk_val("R1 ctrl", v, 32'(NS) << 2);
    for (int s = 0; s < NS; s++) begin
      rd(12'(12'h100 + 4*s), v); chk_val("R8 route zero", v, 32'd0);
    end
    // R1: hold between reads
    @(negedge clk); chk_val("R1 hold", bus_rdata, 32'd0);

    // R2: enable sweep (masks still set -> nothing)
    for (int s = 0; s < NS; s++) begin
      wr(12'h030, s, 0); chk_pend("R2");
    end
    // R4: unmask alternating cores
    for (int s = 0; s < NS; s++) begin
      wr(12'h84C, s, s % 2); chk_pend("R4/R6");
    end
    // R5/R7: routing
    for (int s = 0; s < NS; s++) begin
      wr(12'(12'h100 + 4*s), 32'hFFFF_FFF0 | 32'(s % 4), 0);
      chk_pend("R7");
      rd(12'(12'h100 + 4*s), v);
      chk_val("R5 readback", v, (32'(s % 4) << 8) | 32'(s % 4));
    end
    // unmask everything on both cores
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) wr(12'h84C, s, c);
    chk_pend("R6/R7 all open");
    // R10: line patterns, combinational
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      irq_line = NS'(64'h9E37_79B9_7F4A_7C15 * (p + 1) >> p);
      #1 chk_pend("R10 line");
    end
    irq_line = '1;
    // R3: clear sweep over even sources
    for (int s = 0; s < NS; s += 2) begin
      wr(12'h034, s, 0); chk_pend("R3");
    end
    // R4: core1 masks odd sources; core0 unaffected
    for (int s = 1; s < NS; s += 2) begin
      wr(12'h848, s, 1); chk_pend("R4 bank");
    end
    // R9: out-of-range indices and unmapped addresses
    wr(12'h030, NS, 0);            chk_pend("R9 en idx");
    wr(12'h034, 32'hFFFF_FFFF, 0); chk_pend("R9 clr idx");
    wr(12'h848, 63, 0);            chk_pend("R9 msk idx");
    wr(12'h040, 3, 0);             chk_pend("R9 unmapped");
    wr(12'h101, 3, 0);             chk_pend("R9 misaligned");
    rd(12'h040, v); chk_val("R9 rd unmapped", v, 0);
    rd(12'(12'h100 + 4*NS), v); chk_val("R9 rd beyond", v, 0);
    rd(12'h101, v); chk_val("R9 rd misaligned", v, 0);
    // R10: line change and mask write on same edge
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 12'h848; bus_wdata = 5; bus_core = 0;
    irq_line[5] = 1'b0; irq_line[7] = 1'b1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; m_msk[0][5] = 1'b1;
    chk_pend("R10 same edge");
    irq_line[5] = 1'b1;
    #1 chk_pend("R10 line return");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule